// File: doc/BRIEF.md
# Sound Coprocessor Address Decoder with Serially Loaded Bank

This block sits on the 16-bit address bus of an 8-bit sound coprocessor. Every access goes to one target. The targets are a mirrored local RAM, the FM synthesizer port, the PSG write port, a bank register, and a 32 KB window into the 24-bit main CPU address space. The block drives a select for each target and a RAM address. For window accesses it drives a translated main-bus address. It also selects the byte that goes back to the sound CPU on a read.

The bank register holds 9 bits and takes one bit per write. Each write shifts the register toward bit 0 and puts bit 0 of the write data in at the top. After nine writes the register holds a full bank number. That number forms bits 23..15 of the main-bus address. The low 15 bits of the sound CPU address form the rest.

A window access raises a main-bus request. The sound CPU is held in wait until the main bus acknowledges. Two option inputs gate the FM port and the PSG port.

Top module: `snd_addr_decoder`

## Requirements
- R1: An access (read or write) at 0x0000–0x3FFF asserts `ram_cs`, drives `ram_addr` with address bits 12..0 (so the 8 KB RAM repeats), and a read returns `ram_rdata`.
- R2: An access whose address bits 15..13 equal 3'b010 (0x4000–0x5FFF) asserts `fm_cs` when `fm_en` is 1, and a read returns `fm_rdata`.
- R3: With `fm_en` at 0, an access in the FM range leaves `fm_cs` low, and a read returns 0x00.
- R4: `psg_wr` is asserted only for a write with `psg_en` at 1 whose address ANDed with 0xFFF9 equals 0x7F11 (that is, 0x7F11, 0x7F13, 0x7F15 or 0x7F17). Reads at those addresses never assert it.
- R5: A write whose address bits 15..8 equal 0x60 shifts the 9-bit bank right by one and places `cpu_wdata[0]` in bank bit 8. The other data bits are ignored.
- R6: A bank write held over several cycles shifts only once, on its first cycle.
- R7: An access at 0x8000–0xFFFF asserts `main_req` and drives `main_addr` = {bank, address bits 14..0}. A read returns `main_rdata`.
- R8: `cpu_wait` is high exactly while `main_req` is high and `main_ack` is low.
- R9: A read outside RAM, FM and window returns 0xFF and asserts no select. This covers the bank register, the PSG addresses and all other unmapped addresses.
- R10: Reset (synchronous, active high) clears the bank to 0.
- R11: With neither `cpu_rd` nor `cpu_wr` high, no select, request or wait is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Sound CPU address |
| cpu_rd | input | 1 | Read access active |
| cpu_wr | input | 1 | Write access active |
| cpu_wdata | input | 8 | Sound CPU write data |
| cpu_rdata | output | 8 | Read data returned to the sound CPU |
| cpu_wait | output | 1 | Holds the sound CPU during a window access |
| fm_en | input | 1 | FM port enable option |
| psg_en | input | 1 | PSG port enable option |
| ram_cs | output | 1 | Local RAM select |
| ram_addr | output | 13 | Local RAM address |
| ram_rdata | input | 8 | Local RAM read data |
| fm_cs | output | 1 | FM synthesizer select |
| fm_rdata | input | 8 | FM synthesizer read data |
| psg_wr | output | 1 | PSG write strobe |
| main_req | output | 1 | Main-bus request for a window access |
| main_addr | output | 24 | Translated main-bus address |
| main_ack | input | 1 | Main-bus acknowledge |
| main_rdata | input | 8 | Main-bus read data |

## Verification
The bank register is the hardest state to observe. It has no read path, so its value only shows in the upper bits of `main_addr` during a later window access. The stimulus loads a full 9-bit pattern by writing one bit at a time, with an idle cycle between writes. The write data carries junk in its upper bits. Window reads after the load check the bank the bench model expects. The bench then holds a single bank write high for three cycles and issues a window read. That read shows whether the register shifted once or three times.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;

    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        RGN_RAM  = 3'd0,
        RGN_FM   = 3'd1,
        RGN_PSG  = 3'd2,
        RGN_BANK = 3'd3,
        RGN_WIN  = 3'd4,
        RGN_NONE = 3'd5
    } region_e;

    typedef struct packed {
        logic ram_cs;
        logic fm_cs;
        logic psg_wr;
        logic bank_ld;
        logic win_req;
    } sel_t;

    localparam logic [15:0] PSG_MASK  = 16'hFFF9;
    localparam logic [15:0] PSG_MATCH = 16'h7F11;
    localparam logic [7:0]  BANK_PAGE = 8'h60;
    localparam logic [7:0]  OPEN_BUS  = 8'hFF;

    function automatic region_e classify(input logic [ADDR_W-1:0] a);
        region_e r;
        if (a[15])
            r = RGN_WIN;
        else if (a[15:14] == 2'b00)
            r = RGN_RAM;
        else if (a[15:13] == 3'b010)
            r = RGN_FM;
        else if (a[15:8] == BANK_PAGE)
            r = RGN_BANK;
        else if ((a & PSG_MASK) == PSG_MATCH)
            r = RGN_PSG;
        else
            r = RGN_NONE;
        return r;
    endfunction

endpackage

// File: rtl/snd_region_decode.sv
module snd_region_decode
    import snd_dec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              fm_en,
    input  logic              psg_en,
    output region_e           region,
    output sel_t              sel
);

    logic access;

    always_comb begin
        access = rd | wr;
        region = classify(addr);
        sel    = '0;
        unique case (region)
            RGN_RAM:  sel.ram_cs  = access;
            RGN_FM:   sel.fm_cs   = access & fm_en;
            RGN_PSG:  sel.psg_wr  = wr & psg_en;
            RGN_BANK: sel.bank_ld = wr;
            RGN_WIN:  sel.win_req = access;
            default:  sel         = '0;
        endcase
    end

    always_comb begin
        // R4
        psg_wr_write_only_chk: assert (!sel.psg_wr || (wr && psg_en));
        // R11
        idle_no_select_chk: assert (access || sel == '0);
        // R9
        onehot_sel_chk: assert ($onehot0({sel.ram_cs, sel.fm_cs, sel.psg_wr, sel.bank_ld, sel.win_req}));
    end

endmodule

// File: rtl/snd_bank_shift.sv
module snd_bank_shift #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              din,
    output logic [BANK_W-1:0] bank
);

    logic load_q;
    logic take;

    assign take = load & ~load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank   <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= load;
            if (take)
                bank <= {din, bank[BANK_W-1:1]};
        end
    end

    // R5
    shift_in_top_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (bank[BANK_W-1] == $past(din)) && (bank[BANK_W-2:0] == $past(bank[BANK_W-1:1])));

    // R6
    held_load_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_q) |=> $stable(bank));

endmodule

// File: rtl/snd_rdata_mux.sv
module snd_rdata_mux
    import snd_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  region_e           region,
    input  logic              fm_en,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] fm_rdata,
    input  logic [DATA_W-1:0] main_rdata,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        case (region)
            RGN_RAM: rdata = ram_rdata;
            RGN_FM:  rdata = fm_en ? fm_rdata : '0;
            RGN_WIN: rdata = main_rdata;
            default: rdata = {DATA_W{1'b1}};
        endcase
    end

endmodule

// File: rtl/snd_addr_decoder.sv
module snd_addr_decoder
    import snd_dec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RAM_AW = 13,
    parameter int WIN_AW = 15,
    parameter int BANK_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_wait,
    input  logic                     fm_en,
    input  logic                     psg_en,
    output logic                     ram_cs,
    output logic [RAM_AW-1:0]        ram_addr,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic                     fm_cs,
    input  logic [DATA_W-1:0]        fm_rdata,
    output logic                     psg_wr,
    output logic                     main_req,
    output logic [BANK_W+WIN_AW-1:0] main_addr,
    input  logic                     main_ack,
    input  logic [DATA_W-1:0]        main_rdata
);

    localparam int MAIN_AW = BANK_W + WIN_AW;

    region_e            region;
    sel_t               sel;
    logic [BANK_W-1:0]  bank;

    snd_region_decode u_decode (
        .addr   (cpu_addr),
        .rd     (cpu_rd),
        .wr     (cpu_wr),
        .fm_en  (fm_en),
        .psg_en (psg_en),
        .region (region),
        .sel    (sel)
    );

    snd_bank_shift #(.BANK_W(BANK_W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .load (sel.bank_ld),
        .din  (cpu_wdata[0]),
        .bank (bank)
    );

    snd_rdata_mux #(.DATA_W(DATA_W)) u_rmux (
        .region     (region),
        .fm_en      (fm_en),
        .ram_rdata  (ram_rdata),
        .fm_rdata   (fm_rdata),
        .main_rdata (main_rdata),
        .rdata      (cpu_rdata)
    );

    assign ram_cs    = sel.ram_cs;
    assign ram_addr  = cpu_addr[RAM_AW-1:0];
    assign fm_cs     = sel.fm_cs;
    assign psg_wr    = sel.psg_wr;
    assign main_req  = sel.win_req;
    assign main_addr = MAIN_AW'({bank, cpu_addr[WIN_AW-1:0]});
    assign cpu_wait  = sel.win_req & ~main_ack;

    // R3
    fm_gated_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !fm_en && region == RGN_FM) |-> (cpu_rdata == '0 && !fm_cs));

    // R8
    wait_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_wait |-> (main_req && cpu_addr[ADDR_W-1]));

endmodule

// File: tb/snd_addr_decoder_bench.sv
module snd_addr_decoder_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_wait;
    logic        fm_en = 1'b1, psg_en = 1'b1;
    logic        ram_cs, fm_cs, psg_wr, main_req, main_ack = 1'b0;
    logic [12:0] ram_addr;
    logic [23:0] main_addr;
    logic [7:0]  ram_rdata  = 8'hA5;
    logic [7:0]  fm_rdata   = 8'h3C;
    logic [7:0]  main_rdata = 8'h96;

    always #(CLK_PERIOD/2) clk = ~clk;

    snd_addr_decoder u_snd_addr_decoder (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
        .fm_en(fm_en), .psg_en(psg_en), .ram_cs(ram_cs), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .fm_cs(fm_cs), .fm_rdata(fm_rdata), .psg_wr(psg_wr),
        .main_req(main_req), .main_addr(main_addr), .main_ack(main_ack),
        .main_rdata(main_rdata)
    );

    typedef struct {
        string       rq;
        logic [4:0]  sel;
        logic        chk_rd;
        logic [7:0]  rdata;
        logic        chk_ma;
        logic [23:0] ma;
        logic        chk_ra;
        logic [12:0] ra;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    logic [8:0] m_bank = '0;
    bit         m_prev_ld = 0;

    logic nx_rst = 1'b1, nx_fm = 1'b1, nx_psg = 1'b1, nx_ack = 1'b0;

    task automatic drive(input string rq, input logic [15:0] a, input logic rd,
                         input logic wr, input logic [7:0] d);
        exp_t e;
        bit   acc, ld;
        @(posedge clk);
        #1;
        rst = nx_rst; fm_en = nx_fm; psg_en = nx_psg; main_ack = nx_ack;
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
        acc = rd | wr;
        e.rq = rq;
        e.sel[4] = acc && a < 16'h4000;
        e.sel[3] = acc && a >= 16'h4000 && a < 16'h6000 && nx_fm;
        e.sel[2] = wr && nx_psg && (a == 16'h7F11 || a == 16'h7F13 || a == 16'h7F15 || a == 16'h7F17);
        e.sel[1] = acc && a >= 16'h8000;
        e.sel[0] = e.sel[1] && !nx_ack;
        e.chk_rd = rd;
        if (a < 16'h4000)       e.rdata = ram_rdata;
        else if (a < 16'h6000)  e.rdata = nx_fm ? fm_rdata : 8'h00;
        else if (a >= 16'h8000) e.rdata = main_rdata;
        else                    e.rdata = 8'hFF;
        e.chk_ma = e.sel[1];
        e.ma = {m_bank, a[14:0]};
        e.chk_ra = e.sel[4];
        e.ra = a[12:0];
        expq.push_back(e);
        ld = !nx_rst && wr && a[15:8] == 8'h60;
        if (nx_rst) m_bank = '0;
        else if (ld && !m_prev_ld) m_bank = {d[0], m_bank[8:1]};
        m_prev_ld = ld;
    endtask

    task automatic fail(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    endtask

    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            logic [4:0] s;
            e = expq.pop_front();
            s = {ram_cs, fm_cs, psg_wr, main_req, cpu_wait};
            checks++;
            if (s !== e.sel) fail(e.rq, "selects", 32'(s), 32'(e.sel));
            if (e.chk_rd) begin
                checks++;
                if (cpu_rdata !== e.rdata) fail(e.rq, "rdata", 32'(cpu_rdata), 32'(e.rdata));
            end
            if (e.chk_ma) begin
                checks++;
                if (main_addr !== e.ma) fail(e.rq, "main_addr", 32'(main_addr), 32'(e.ma));
            end
            if (e.chk_ra) begin
                checks++;
                if (ram_addr !== e.ra) fail(e.rq, "ram_addr", 32'(ram_addr), 32'(e.ra));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [8:0] pat;
        // R10: bank is 0 under reset and right after it
        drive("R10", 16'h8123, 1, 0, 8'h00);
        nx_rst = 1'b0;
        drive("R10", 16'h8123, 1, 0, 8'h00);
        // R11: idle
        drive("R11", 16'h1234, 0, 0, 8'h00);
        drive("R11", 16'h9000, 0, 0, 8'h00);
        // R1: RAM with mirroring
        drive("R1", 16'h2345, 1, 0, 8'h00);
        drive("R1", 16'h3FFF, 0, 1, 8'h11);
        drive("R1", 16'h0001, 1, 0, 8'h00);
        // R2: FM
        drive("R2", 16'h4000, 1, 0, 8'h00);
        drive("R2", 16'h5FFF, 0, 1, 8'h22);
        // R3: FM disabled
        nx_fm = 1'b0;
        drive("R3", 16'h4001, 1, 0, 8'h00);
        drive("R3", 16'h5000, 0, 1, 8'h33);
        nx_fm = 1'b1;
        // R4: PSG decode
        drive("R4", 16'h7F11, 0, 1, 8'h44);
        drive("R4", 16'h7F17, 0, 1, 8'h45);
        drive("R4", 16'h7F12, 0, 1, 8'h46);
        drive("R4", 16'h7F19, 0, 1, 8'h47);
        nx_psg = 1'b0;
        drive("R4", 16'h7F13, 0, 1, 8'h48);
        nx_psg = 1'b1;
        // R9: open-bus reads
        drive("R9", 16'h7F11, 1, 0, 8'h00);
        drive("R9", 16'h6000, 1, 0, 8'h00);
        drive("R9", 16'h7000, 1, 0, 8'h00);
        drive("R9", 16'h7F00, 1, 0, 8'h00);
        // R5: serial load of 9'h1A5, upper data bits junk
        pat = 9'h1A5;
        for (int i = 0; i < 9; i++) begin
            drive("R5", 16'h6000 + 16'(i), 0, 1, {7'b1010110, pat[i]});
            drive("R5", 16'h0000, 0, 0, 8'h00);
        end
        drive("R5", 16'h8000, 1, 0, 8'h00);
        // R7: window mapping, ack present
        nx_ack = 1'b1;
        drive("R7", 16'hFFFF, 1, 0, 8'h00);
        drive("R7", 16'hC0DE, 0, 1, 8'h5A);
        // R8: wait while not acknowledged
        nx_ack = 1'b0;
        drive("R8", 16'hC0DE, 1, 0, 8'h00);
        drive("R8", 16'hC0DE, 1, 0, 8'h00);
        nx_ack = 1'b1;
        drive("R8", 16'hC0DE, 1, 0, 8'h00);
        nx_ack = 1'b0;
        // R6: held bank write shifts once
        drive("R6", 16'h60FF, 0, 1, 8'h01);
        drive("R6", 16'h60FF, 0, 1, 8'h01);
        drive("R6", 16'h60FF, 0, 1, 8'h01);
        drive("R6", 16'h8001, 1, 0, 8'h00);
        drive("R5", 16'h6010, 0, 1, 8'hFE);
        drive("R5", 16'hABCD, 1, 0, 8'h00);
        drive("R11", 16'h0000, 0, 0, 8'h00);
        @(posedge clk);
        @(posedge clk);
        finish_run();
    end

endmodule